// File: doc/BRIEF.md
# Status Flag Manipulation Unit

This block keeps the eight-flag processor status byte and executes the one-cycle commands that act on it. A command can force any single flag to 1 or to 0, either by a 3-bit position index or by a named per-flag command code. Commands can also move one bit between a data operand and the bit-copy flag T. A "store" copies a chosen operand bit into T. A "load" returns the operand with a chosen bit replaced by the current T.

The arithmetic unit updates flags through a separate masked write port. When that port and a command both target the same flag in one cycle, the command wins for that flag, and the remaining arithmetic updates still take effect. The status byte and the load result are registered, and every command is visible on the outputs one clock edge after it is presented. The operand width is a parameter. The status byte is always eight bits, with these fixed positions: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.

Top module: `stat_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears `sreg`, `bld_data` and `bld_valid` to 0 at the next clock edge.
- R2: `cmd_op`=5'b00001 (indexed set) makes `sreg[cmd_idx]` 1 after the next edge. No other flag changes.
- R3: `cmd_op`=5'b00010 (indexed clear) makes `sreg[cmd_idx]` 0 after the next edge. No other flag changes.
- R4: `cmd_op`=5'b00011 (bit store) copies `cmd_opnd[cmd_bit]` into T (`sreg[6]`) after the next edge. No other flag changes.
- R5: `cmd_op`=5'b00100 (bit load) puts `cmd_opnd` on `bld_data` after the next edge, with bit `cmd_bit` replaced by the T value held before that edge, and pulses `bld_valid` for one cycle. No flag changes. `bld_data` keeps its value until the next load.
- R6: A named command has `cmd_op[4]`=1. Bit 3 selects set (1) or clear (0), and bits 2:0 name the flag: 0=C, 1=N, 2=Z, 3=I, 4=S, 5=V, 6=T, 7=H. Only the named flag changes, after the next edge.
- R7: For each i where `alu_we[i]`=1, `sreg[i]` takes `alu_flags[i]` after the next edge, unless a command targets that flag.
- R8: When a command targets a flag that the arithmetic port also writes in the same cycle, the command's value is stored for that flag. The other flags written by the arithmetic port still update.
- R9: `cmd_op` = 0 and the reserved codes 5 to 15 have no effect. The flags change only through the arithmetic port, and `bld_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 5 | Command code |
| cmd_idx | input | 3 | Flag position for the indexed set and clear commands |
| cmd_bit | input | $clog2(DATA_W) | Operand bit select for bit store and bit load |
| cmd_opnd | input | DATA_W | Register operand |
| alu_we | input | 8 | Per-flag write enables from the arithmetic unit |
| alu_flags | input | 8 | Flag values from the arithmetic unit |
| sreg | output | 8 | Registered status byte |
| bld_data | output | DATA_W | Registered bit-load result |
| bld_valid | output | 1 | One-cycle pulse after a bit load |

## Verification
The bench builds the unit with DATA_W=16. This gives a 4-bit bit select, so bit store and bit load are exercised on operand bits 8 to 15, above the width of the status byte. All eight indexed positions and all sixteen named command codes are driven. Collisions between commands and arithmetic writes are placed on the targeted flag and on the other flags, including a store into T while the arithmetic port writes the opposite T value. A long stretch of random commands mixed with random arithmetic writes covers the remaining cases.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  localparam int FLAGS = 8;
  localparam int IDX_W = $clog2(FLAGS);
  localparam int OP_W  = 5;

  localparam int POS_C = 0;
  localparam int POS_Z = 1;
  localparam int POS_N = 2;
  localparam int POS_V = 3;
  localparam int POS_S = 4;
  localparam int POS_H = 5;
  localparam int POS_T = 6;
  localparam int POS_I = 7;

  localparam logic [OP_W-1:0] OP_NOP  = 5'd0;
  localparam logic [OP_W-1:0] OP_SETI = 5'd1;
  localparam logic [OP_W-1:0] OP_CLRI = 5'd2;
  localparam logic [OP_W-1:0] OP_BST  = 5'd3;
  localparam logic [OP_W-1:0] OP_BLD  = 5'd4;

  localparam int OP_NAMED_BIT = 4;
  localparam int OP_SETVAL_BIT = 3;

  function automatic logic [IDX_W-1:0] name_to_pos(input logic [2:0] code);
    logic [IDX_W-1:0] p;
    case (code)
      3'd0:    p = IDX_W'(POS_C);
      3'd1:    p = IDX_W'(POS_N);
      3'd2:    p = IDX_W'(POS_Z);
      3'd3:    p = IDX_W'(POS_I);
      3'd4:    p = IDX_W'(POS_S);
      3'd5:    p = IDX_W'(POS_V);
      3'd6:    p = IDX_W'(POS_T);
      default: p = IDX_W'(POS_H);
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] opnd,
  output logic [FLAGS-1:0]  frc_mask,
  output logic [FLAGS-1:0]  frc_val,
  output logic              ld_en
);

  logic              sel_bit;
  logic              tgt_en;
  logic              tgt_val;
  logic [IDX_W-1:0]  tgt_pos;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (bit_sel == BIT_W'(i)) sel_bit = opnd[i];
    end
  end

  always_comb begin
    tgt_en  = 1'b0;
    tgt_val = 1'b0;
    tgt_pos = '0;
    ld_en   = 1'b0;
    if (op[OP_NAMED_BIT]) begin
      tgt_en  = 1'b1;
      tgt_val = op[OP_SETVAL_BIT];
      tgt_pos = name_to_pos(op[2:0]);
    end else begin
      case (op)
        OP_SETI: begin tgt_en = 1'b1; tgt_val = 1'b1; tgt_pos = idx; end
        OP_CLRI: begin tgt_en = 1'b1; tgt_val = 1'b0; tgt_pos = idx; end
        OP_BST:  begin tgt_en = 1'b1; tgt_val = sel_bit; tgt_pos = IDX_W'(POS_T); end
        OP_BLD:  ld_en = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    frc_mask = '0;
    frc_val  = '0;
    for (int i = 0; i < FLAGS; i++) begin
      if (tgt_en && tgt_pos == IDX_W'(i)) begin
        frc_mask[i] = 1'b1;
        frc_val[i]  = tgt_val;
      end
    end
  end

  // R2 R3 R6: a command forces at most one flag
  p_single_target_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(frc_mask));

  // R5: a load never forces a flag
  p_load_no_force_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> (frc_mask == '0));

endmodule

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg
  import sfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FLAGS-1:0] frc_mask,
  input  logic [FLAGS-1:0] frc_val,
  input  logic [FLAGS-1:0] alu_we,
  input  logic [FLAGS-1:0] alu_val,
  output logic [FLAGS-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < FLAGS; i++) begin
        if (frc_mask[i])     flags_q[i] <= frc_val[i];
        else if (alu_we[i])  flags_q[i] <= alu_val[i];
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (flags_q == '0));

  for (genvar g = 0; g < FLAGS; g++) begin : g_chk
    p_force_wins_r8: assert property (@(posedge clk) disable iff (rst)
      frc_mask[g] |=> (flags_q[g] == $past(frc_val[g])));
    p_alu_write_r7: assert property (@(posedge clk) disable iff (rst)
      (alu_we[g] && !frc_mask[g]) |=> (flags_q[g] == $past(alu_val[g])));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!alu_we[g] && !frc_mask[g]) |=> $stable(flags_q[g]));
  end

endmodule

// File: rtl/sfu_bit_insert.sv
module sfu_bit_insert #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] opnd,
  input  logic              t_bit,
  output logic [DATA_W-1:0] res_q,
  output logic              vld_q
);

  logic [DATA_W-1:0] ins;

  for (genvar g = 0; g < DATA_W; g++) begin : g_ins
    assign ins[g] = (bit_sel == BIT_W'(g)) ? t_bit : opnd[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ld_en;
      if (ld_en) res_q <= ins;
    end
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> vld_q);

  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(res_q) && !vld_q);

  p_t_inserted_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (res_q[$past(bit_sel)] == $past(t_bit)));

endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        cmd_op,
  input  logic [2:0]        cmd_idx,
  input  logic [BIT_W-1:0]  cmd_bit,
  input  logic [DATA_W-1:0] cmd_opnd,
  input  logic [7:0]        alu_we,
  input  logic [7:0]        alu_flags,
  output logic [7:0]        sreg,
  output logic [DATA_W-1:0] bld_data,
  output logic              bld_valid
);

  logic [FLAGS-1:0] frc_mask;
  logic [FLAGS-1:0] frc_val;
  logic             ld_en;

  sfu_decode #(.DATA_W(DATA_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .op       (cmd_op),
    .idx      (cmd_idx),
    .bit_sel  (cmd_bit),
    .opnd     (cmd_opnd),
    .frc_mask (frc_mask),
    .frc_val  (frc_val),
    .ld_en    (ld_en)
  );

  sfu_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .frc_mask (frc_mask),
    .frc_val  (frc_val),
    .alu_we   (alu_we),
    .alu_val  (alu_flags),
    .flags_q  (sreg)
  );

  sfu_bit_insert #(.DATA_W(DATA_W)) u_ins (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .bit_sel (cmd_bit),
    .opnd    (cmd_opnd),
    .t_bit   (sreg[POS_T]),
    .res_q   (bld_data),
    .vld_q   (bld_valid)
  );

  p_store_t_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_BST) |=> (sreg[POS_T] == $past(cmd_opnd[cmd_bit])));

  p_named_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_op[OP_NAMED_BIT] |=>
      (sreg[name_to_pos($past(cmd_op[2:0]))] == $past(cmd_op[OP_SETVAL_BIT])));

  p_indexed_set_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_SETI) |=> sreg[$past(cmd_idx)]);

  p_indexed_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_CLRI) |=> !sreg[$past(cmd_idx)]);

  p_load_flags_r5: assert property (@(posedge clk) disable iff (rst)
    ((cmd_op == OP_BLD) && (alu_we == '0)) |=> $stable(sreg));

  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_op[OP_NAMED_BIT] && (cmd_op == OP_NOP || cmd_op > OP_BLD) && (alu_we == '0))
      |=> ($stable(sreg) && !bld_valid));

endmodule

// File: tb/sim_stat_flag_unit.sv
module sim_stat_flag_unit;

  localparam int DW = 16;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    cmd_op = '0;
  logic [2:0]    cmd_idx = '0;
  logic [BW-1:0] cmd_bit = '0;
  logic [DW-1:0] cmd_opnd = '0;
  logic [7:0]    alu_we = '0;
  logic [7:0]    alu_flags = '0;
  logic [7:0]    sreg;
  logic [DW-1:0] bld_data;
  logic          bld_valid;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  string tag = "R1";
  string tag_q = "R1";

  logic [7:0]    m_sreg = '0;
  logic [DW-1:0] m_res = '0;
  logic          m_val = 1'b0;
  int name_pos [8] = '{0, 2, 1, 7, 4, 3, 6, 5};

  always #5 clk = ~clk;

  stat_flag_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_bit(cmd_bit),
    .cmd_opnd(cmd_opnd), .alu_we(alu_we), .alu_flags(alu_flags),
    .sreg(sreg), .bld_data(bld_data), .bld_valid(bld_valid)
  );

  // behavioural reference model
  always @(posedge clk) begin : model
    logic [7:0] nx;
    logic [DW-1:0] r;
    if (rst) begin
      m_sreg <= '0; m_res <= '0; m_val <= 1'b0;
    end else begin
      nx = m_sreg;
      for (int i = 0; i < 8; i++) if (alu_we[i]) nx[i] = alu_flags[i];
      m_val <= 1'b0;
      if (cmd_op[4]) nx[name_pos[cmd_op[2:0]]] = cmd_op[3];
      else if (cmd_op == 5'd1) nx[cmd_idx] = 1'b1;
      else if (cmd_op == 5'd2) nx[cmd_idx] = 1'b0;
      else if (cmd_op == 5'd3) nx[6] = cmd_opnd[cmd_bit];
      else if (cmd_op == 5'd4) begin
        r = cmd_opnd;
        r[cmd_bit] = m_sreg[6];
        m_res <= r;
        m_val <= 1'b1;
      end
      m_sreg <= nx;
    end
    tag_q <= tag;
    chk_on <= 1'b1;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (sreg !== m_sreg) begin
        errors++;
        $display("FAIL %s sreg: actual %02h expected %02h", tag_q, sreg, m_sreg);
      end
      checks++;
      if (bld_valid !== m_val) begin
        errors++;
        $display("FAIL %s bld_valid: actual %0b expected %0b", tag_q, bld_valid, m_val);
      end
      checks++;
      if (bld_data !== m_res) begin
        errors++;
        $display("FAIL %s bld_data: actual %04h expected %04h", tag_q, bld_data, m_res);
      end
    end
  end

  task automatic cyc(input logic [4:0] op, input logic [2:0] idx, input logic [BW-1:0] b,
                     input logic [DW-1:0] opnd, input logic [7:0] we, input logic [7:0] fl,
                     input string t);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_bit = b; cmd_opnd = opnd;
    alu_we = we; alu_flags = fl; tag = t;
  endtask

  task automatic idle(input string t);
    cyc(5'd0, 3'd0, '0, '0, 8'h00, 8'h00, t);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    rst = 1'b1;
    repeat (3) idle("R1");
    @(negedge clk); rst = 1'b0;
    // R2 indexed set, R3 indexed clear
    for (int i = 0; i < 8; i++) cyc(5'd1, 3'(i), '0, '0, 8'h00, 8'h00, "R2");
    for (int i = 0; i < 8; i++) cyc(5'd2, 3'(7 - i), '0, '0, 8'h00, 8'h00, "R3");
    // R6 named set then clear of each flag
    for (int i = 0; i < 8; i++) cyc(5'b11000 | 5'(i), 3'd0, '0, '0, 8'h00, 8'h00, "R6");
    for (int i = 0; i < 8; i++) cyc(5'b10000 | 5'(i), 3'd0, '0, '0, 8'h00, 8'h00, "R6");
    // R4 bit store from every operand bit
    for (int i = 0; i < DW; i++) begin
      cyc(5'd3, 3'd0, BW'(i), 16'hA5C3 ^ DW'(i), 8'h00, 8'h00, "R4");
      idle("R4");
    end
    // R5 bit load with T=1 and T=0
    cyc(5'd1, 3'd6, '0, '0, 8'h00, 8'h00, "R5");
    for (int i = 0; i < DW; i++) cyc(5'd4, 3'd0, BW'(i), 16'h0000, 8'h00, 8'h00, "R5");
    idle("R5");
    cyc(5'd2, 3'd6, '0, '0, 8'h00, 8'h00, "R5");
    for (int i = 0; i < DW; i++) cyc(5'd4, 3'd0, BW'(i), 16'hFFFF, 8'h00, 8'h00, "R5");
    idle("R5");
    idle("R5");
    // R7 arithmetic write port
    cyc(5'd0, 3'd0, '0, '0, 8'hFF, 8'h5A, "R7");
    cyc(5'd0, 3'd0, '0, '0, 8'h0F, 8'h00, "R7");
    cyc(5'd0, 3'd0, '0, '0, 8'hF0, 8'h3C, "R7");
    // R8 collisions
    cyc(5'd1, 3'd3, '0, '0, 8'hFF, 8'h00, "R8");
    cyc(5'd2, 3'd3, '0, '0, 8'hFF, 8'hFF, "R8");
    cyc(5'd3, 3'd0, 4'd9, 16'h0200, 8'h40, 8'h00, "R8");
    cyc(5'd3, 3'd0, 4'd9, 16'h0000, 8'hFF, 8'hFF, "R8");
    cyc(5'b11011, 3'd0, '0, '0, 8'h88, 8'h00, "R8");
    cyc(5'd4, 3'd0, 4'd2, 16'h1234, 8'h40, 8'h00, "R8");
    idle("R8");
    // R9 reserved codes
    cyc(5'd0, 3'd0, '0, '0, 8'hFF, 8'hA5, "R9");
    for (int c = 5; c < 16; c++) cyc(5'(c), 3'd2, 4'd6, 16'hFFFF, 8'h00, 8'h00, "R9");
    cyc(5'd7, 3'd1, '0, '0, 8'h03, 8'h00, "R9");
    // mid-run reset
    cyc(5'd4, 3'd0, 4'd1, 16'h00F0, 8'hFF, 8'hFF, "R1");
    @(negedge clk); rst = 1'b1; tag = "R1";
    idle("R1");
    @(negedge clk); rst = 1'b0;
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      cyc(op, 3'($urandom), BW'($urandom), DW'($urandom),
          ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00, 8'($urandom), "R8");
    end
    idle("R8");
    idle("R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule